// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the 32-bit control registers of a host bridge in a word-indexed window. A simple bus drives it: a write strobe, a read strobe, a word index and write data. The word index is the byte offset of the register divided by four. Most registers are plain storage that reads back what was last written.

A few registers have side effects. The interrupt-enable mask cannot be written directly. It changes only through a set address, which ORs the written bits in, and a clear address, which removes them. The enable mask and the interrupt-status word are read-only.

Writing the general-configuration word with its boot bit (bit 2) going from 0 to 1 raises a one-cycle reset request toward the system. A write that misses the window or hits a read-only word changes nothing and pulses a write-error flag for one cycle.

Top module: `hb_ctrl_regfile`

## Requirements
- R1: After reset, each word holds its default value. Index 0 (byte 0x00) = 0xC40, index 1 (0x04) = 0x1384, index 2 (0x08) = 0x2BFF8010, index 3 (0x0C) = 0x255E0091, index 4 (0x10) = 0x6140, index 7 (0x1C) = 0x1FF, index 8 (0x20) = 0x1FF, index 26 (0x68) = 0x8, index 27 (0x6C) = 0x10000000. Every other word is zero.
- R2: Every in-window word other than indices 14 and 15 stores a written 32-bit value and returns it on later reads.
- R3: A write to index 12 (byte 0x30) stores the value at index 12 and ORs it into the enable mask at index 14 (0x38).
- R4: A write to index 13 (byte 0x34) stores the value at index 13 and clears each bit of the enable mask where the written value is 1.
- R5: Writes to index 14 (enable mask) and index 15 (status, which stays zero) leave both words unchanged. On the cycle after such a write, `wr_err` is 1.
- R6: A write to index 1 whose data has bit 2 set, while the stored bit 2 is 0, makes `reset_req` 1 for exactly the cycle after the write. The written value is stored whether or not a request is raised. A write that leaves bit 2 at 1, or clears it, raises no request.
- R7: A write to an index of 28 or more changes no register and makes `wr_err` 1 for the cycle after it. A read of such an index returns zero.
- R8: A read returns data one cycle after `bus_rd`, with `rd_valid` high for that cycle only. When a read and a write hit the same word in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | ADDR_W (6) | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| reset_req | output | 1 | One-cycle system reset request |
| wr_err | output | 1 | One-cycle flag for a dropped write |

## Verification
The checker watches four things on every cycle. A reset request only follows a configuration write that carries bit 2. An error pulse only follows a write to a read-only or out-of-window index. Read-valid only follows a read strobe. An out-of-window read always returns zero. Several behaviours need the bench's sequences, because each one depends on earlier writes. These are the defaults held after reset, the set and clear arithmetic on the enable mask, the fact that a dropped write leaves the stored words as they were, the absence of a request when bit 2 was already set, and read-before-write ordering.

// File: rtl/hbr_pkg.sv
// Package: shared sizes, special word indices and the reset-default table
// of the host bridge control register file. Assumes 32-bit words.
package hbr_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_REGS   = 28;
    localparam int IDX_GENCFG = 1;
    localparam int IDX_ENSET  = 12;
    localparam int IDX_ENCLR  = 13;
    localparam int IDX_ENMASK = 14;
    localparam int IDX_STATUS = 15;
    localparam int BOOT_BIT   = 2;

    // Default value loaded into word idx on reset.
    function automatic logic [WORD_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/hbr_decode.sv
// Decoder: turns a bus strobe and word index into per-word write selects
// and a dropped-write indication. Assumes the window starts at index 0.
module hbr_decode
    import hbr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_idx,
    output logic              in_window,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic              wr_drop
);
    logic read_only;

    // Classify the index: inside the window, and read-only or not.
    always_comb begin
        in_window = (int'(bus_idx) < NUM_REGS);
        read_only = (int'(bus_idx) == IDX_ENMASK) || (int'(bus_idx) == IDX_STATUS);
        wr_drop   = bus_wr && (!in_window || read_only);
    end

    // One select line per word; only writable words are ever selected.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign wr_sel[i] = bus_wr && !read_only && (bus_idx == ADDR_W'(i));
    end
endmodule

// File: rtl/hbr_store.sv
// Storage: holds all words with their reset defaults, applies the
// enable set/clear side effects and detects the boot-bit rising edge.
// Assumes at most one word selected per cycle.
module hbr_store
    import hbr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGS-1:0]            wr_sel,
    input  logic [WORD_W-1:0]              wdata,
    output logic [NUM_REGS-1:0][WORD_W-1:0] words,
    output logic                           boot_req
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        if (i == IDX_ENMASK) begin : g_mask
            // Enable mask: changed only through the set and clear words.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[i] <= reg_default(i);
                else if (wr_sel[IDX_ENSET])
                    words[i] <= words[i] | wdata;
                else if (wr_sel[IDX_ENCLR])
                    words[i] <= words[i] & ~wdata;
            end
        end else if (i == IDX_STATUS) begin : g_status
            // Status word: no source feeds it here, so it holds its default.
            always_ff @(posedge clk) begin
                words[i] <= reg_default(i);
            end
        end else begin : g_plain
            // Plain storage word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[i] <= reg_default(i);
                else if (wr_sel[i])
                    words[i] <= wdata;
            end
        end
    end

    // Reset request pulse on a 0-to-1 move of the boot bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            boot_req <= 1'b0;
        else
            boot_req <= wr_sel[IDX_GENCFG] && !words[IDX_GENCFG][BOOT_BIT]
                        && wdata[BOOT_BIT];
    end
endmodule

// File: rtl/hbr_rdport.sv
// Read port: registers the selected word one cycle after a read strobe.
// An index outside the window reads as zero.
module hbr_rdport
    import hbr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_rd,
    input  logic [ADDR_W-1:0]               bus_idx,
    input  logic                            in_window,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] words,
    output logic [WORD_W-1:0]               rd_data,
    output logic                            rd_valid
);
    // Capture the word (pre-write value) and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= bus_rd;
            if (bus_rd)
                rd_data <= in_window ? words[int'(bus_idx) % NUM_REGS] : '0;
        end
    end
endmodule

// File: rtl/hb_ctrl_regfile.sv
// Top: host bridge control register file. Connects the decoder, the
// storage and the read port, and registers the dropped-write flag.
// Assumes a synchronous active-low reset and single-cycle strobes.
module hb_ctrl_regfile
    import hbr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_idx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              reset_req,
    output logic              wr_err
);
    logic                            in_window;
    logic [NUM_REGS-1:0]             wr_sel;
    logic                            wr_drop;
    logic [NUM_REGS-1:0][WORD_W-1:0] words;

    hbr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .bus_wr    (bus_wr),
        .bus_idx   (bus_idx),
        .in_window (in_window),
        .wr_sel    (wr_sel),
        .wr_drop   (wr_drop)
    );

    hbr_store store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wdata    (bus_wdata),
        .words    (words),
        .boot_req (reset_req)
    );

    hbr_rdport #(.ADDR_W(ADDR_W)) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_idx   (bus_idx),
        .in_window (in_window),
        .words     (words),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // Register the dropped-write flag as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_err <= 1'b0;
        else
            wr_err <= wr_drop;
    end
endmodule

// File: rtl/hbr_checker.sv
// Checker: port-level properties of the register file, bound to the top.
module hbr_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_idx,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       rd_data,
    input logic              rd_valid,
    input logic              reset_req,
    input logic              wr_err
);
    // R6
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(bus_wr && bus_idx == ADDR_W'(1) && bus_wdata[2]));

    // R5
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(bus_wr && (int'(bus_idx) >= 28 || bus_idx == ADDR_W'(14)
                                    || bus_idx == ADDR_W'(15))));

    // R8
    rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_rd));

    // R8
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid);

    // R7
    outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_idx) >= 28) |=> (rd_data == 32'h0));

    // R6
    req_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && wr_err));
endmodule

bind hb_ctrl_regfile hbr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .reset_req (reset_req),
    .wr_err    (wr_err)
);

// File: tb/hb_ctrl_regfile_tb.sv
`timescale 1ns/1ps
module hb_ctrl_regfile_tb_top;
    localparam int ADDR_W = 6;
    localparam int NV = 22;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_idx = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       rd_data;
    logic              rd_valid;
    logic              reset_req;
    logic              wr_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hb_ctrl_regfile #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .reset_req(reset_req), .wr_err(wr_err)
    );

    // Vector table: op 1 = write (expect = wr_err value), op 0 = read (expect = data).
    localparam logic       V_OP  [NV] = '{1,0, 1,0, 1,0, 1,0,0, 1,0, 1,0,0, 1,0, 1,0, 1,0, 1,0};
    localparam logic [7:0] V_OFS [NV] = '{8'h10,8'h10, 8'h40,8'h40, 8'h5C,8'h5C,
                                          8'h30,8'h38,8'h30, 8'h30,8'h38,
                                          8'h34,8'h38,8'h34, 8'h38,8'h38,
                                          8'h3C,8'h3C, 8'h80,8'h80, 8'h2C,8'h2C};
    localparam logic [31:0] V_DAT [NV] = '{32'hA5A5_0001,0, 32'hDEAD_BEEF,0, 32'h1234_5678,0,
                                           32'h0000_00F0,0,0, 32'h0000_000F,0,
                                           32'h0000_0030,0,0, 32'hFFFF_FFFF,0,
                                           32'h0000_0001,0, 32'h0000_0001,0, 32'h0000_0055,0};
    localparam logic [31:0] V_EXP [NV] = '{0,32'hA5A5_0001, 0,32'hDEAD_BEEF, 0,32'h1234_5678,
                                           0,32'h0000_00F0,32'h0000_00F0, 0,32'h0000_00FF,
                                           0,32'h0000_00CF,32'h0000_0030, 1,32'h0000_00CF,
                                           1,32'h0, 1,32'h0, 0,32'h0000_0055};
    localparam int V_REQ [NV] = '{2,2, 2,2, 2,2, 3,3,3, 3,3, 4,4,4, 5,5, 5,5, 7,7, 2,2};

    function automatic logic [31:0] exp_default(input int idx);
        case (idx)
            0: return 32'hC40;        1: return 32'h1384;
            2: return 32'h2BFF8010;   3: return 32'h255E0091;
            4: return 32'h6140;       7: return 32'h1FF;
            8: return 32'h1FF;        26: return 32'h8;
            27: return 32'h10000000;  default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic last_req, last_err;

    task automatic do_write(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_idx = ofs[7:2]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_req = reset_req; last_err = wr_err;
    endtask

    task automatic do_read(input logic [7:0] ofs, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_idx = ofs[7:2];
        @(negedge clk);
        bus_rd = 1'b0;
        check("R8 rd_valid", {31'b0, rd_valid}, 32'h1);
        d = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle rd_valid", {31'b0, rd_valid}, 32'h0);
        check("R6 idle reset_req", {31'b0, reset_req}, 32'h0);
        // R1: every word holds its default
        for (int i = 0; i < 28; i++) begin
            do_read(8'(i * 4), v);
            check("R1 default", v, exp_default(i));
        end
        // Vector walk: R2 R3 R4 R5 R7
        for (int k = 0; k < NV; k++) begin
            if (V_OP[k]) begin
                do_write(V_OFS[k], V_DAT[k]);
                check($sformatf("R%0d wr_err", V_REQ[k]), {31'b0, last_err}, V_EXP[k]);
            end else begin
                do_read(V_OFS[k], v);
                check($sformatf("R%0d read", V_REQ[k]), v, V_EXP[k]);
            end
        end
        // R7: out-of-window write left the edge word and status alone
        do_read(8'h24, v);  check("R7 no change", v, 32'h0);
        do_read(8'h3C, v);  check("R5 status zero", v, 32'h0);
        // R6: boot bit transitions
        do_write(8'h04, 32'h1384);
        check("R6 already set no req", {31'b0, last_req}, 32'h0);
        do_write(8'h04, 32'h1380);
        check("R6 clear no req", {31'b0, last_req}, 32'h0);
        do_read(8'h04, v);  check("R6 stored", v, 32'h1380);
        do_write(8'h04, 32'h0004);
        check("R6 rise req", {31'b0, last_req}, 32'h1);
        check("R6 no err", {31'b0, last_err}, 32'h0);
        @(negedge clk);
        check("R6 one cycle", {31'b0, reset_req}, 32'h0);
        do_read(8'h04, v);  check("R6 stored on req", v, 32'h0004);
        // R8: simultaneous read and write returns the old value
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_idx = 6'h11; bus_wdata = 32'hCAFE_0011;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R8 read-before-write", rd_data, 32'h0);
        @(negedge clk);
        check("R8 valid one cycle", {31'b0, rd_valid}, 32'h0);
        do_read(8'h44, v);  check("R8 new value", v, 32'hCAFE_0011);
        // R1: reset restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(8'h38, v);  check("R1 mask after reset", v, 32'h0);
        do_read(8'h04, v);  check("R1 cfg after reset", v, 32'h1384);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule